// File: doc/BRIEF.md
# Paired Lock Agreement Monitor

This block supervises two mechanisms, a side A and a side B, that should lock and unlock together. Each side supplies one flag that is high while that side is locked. On every clock edge the block re-evaluates the pair and publishes a 3-bit mode code. Code 1 means both sides are locked. Code 2 means the sides disagree. Code 3 means both sides are free. Code 4 means the sides have disagreed for too long. A separate fault flag mirrors code 4 so that downstream logic can use it directly.

Time is measured with a strobe, `tick`, that is high for one clock per time unit. While the pair disagrees, the block counts strobes. When the count runs past a parameterised limit, `TIMEOUT_TICKS` (default 10), the mode moves to the latched fault code. The fault code stays as long as the sides still disagree, even if the disagreeing side changes. It clears only when the sides agree again, and it then goes to 1 or 3 to match the agreement. Both inputs are taken to be synchronous to the clock already.

The controller has five states:

| State | Mode | Meaning |
|---|---|---|
| ST_IDLE | 0 | Held while in reset |
| ST_BOTH_LOCKED | 1 | Both sides locked |
| ST_SPLIT | 2 | The sides disagree |
| ST_BOTH_FREE | 3 | Both sides free |
| ST_FAULT | 4 | The disagreement has lasted past the limit |

The transitions are:

- **settle**: any state except ST_FAULT goes to ST_BOTH_LOCKED or ST_BOTH_FREE when the sides agree.
- **diverge**: ST_IDLE, ST_BOTH_LOCKED or ST_BOTH_FREE goes to ST_SPLIT when the sides disagree.
- **escalate**: ST_SPLIT goes to ST_FAULT on the strobe beyond the limit.
- **hold**: ST_SPLIT stays in ST_SPLIT, and ST_FAULT stays in ST_FAULT, while the sides still disagree.
- **recover**: ST_FAULT goes to ST_BOTH_LOCKED or ST_BOTH_FREE once the sides agree.

Top module: `lock_pair_monitor`

## Requirements
- R1: One clock edge after both lock flags are high (reset low), `mode` is 1.
- R2: One clock edge after exactly one lock flag is high, `mode` is 2, whichever side it is. This applies from any state other than fault, as long as the timeout has not run out.
- R3: One clock edge after both lock flags are low, `mode` is 3. Code 2 is never reported for a pair that was both free.
- R4: The edge that enters code 2 counts no strobe. From code 2, the mode becomes 4 on the edge of the (TIMEOUT_TICKS+1)-th strobe while the sides still disagree. Before that edge it remains 2.
- R5: While `mode` is 4 and the sides disagree (on either side), `mode` stays 4 and never returns to 2.
- R6: From `mode` 4, both sides locked gives 1 on the next edge, and both sides free gives 3 on the next edge.
- R7: The strobe count restarts from zero on every entry into code 2. A disagreement that ended before the timeout leaves no credit toward a later one.
- R8: While `rst` is high, `mode` is 0 and `fault` is 0. The first edge after reset is released sets `mode` from the sampled flags.
- R9: `fault` is 1 exactly when `mode` is 4.
- R10: Without strobes, code 2 persists for any number of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock time-unit strobe |
| lock_a | input | 1 | Side A locked flag |
| lock_b | input | 1 | Side B locked flag |
| mode | output | 3 | Mode code: 0 reset, 1 both locked, 2 disagree, 3 both free, 4 fault |
| fault | output | 1 | High while mode is 4 |

## Verification
Every result is registered, so a change on the lock flags or on the strobe shows on `mode` and `fault` after exactly one rising edge. The bench drives inputs on the falling edge, waits for one rising edge, and samples on the following falling edge. For the timeout, strobes are counted from the first edge after the diverge edge. The mode is checked after each of the first TIMEOUT_TICKS strobes, where it must still be 2, and again after the one beyond, where it must be 4.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_BOTH_LOCKED = 3'd1,
        ST_SPLIT       = 3'd2,
        ST_BOTH_FREE   = 3'd3,
        ST_FAULT       = 3'd4
    } lpm_state_e;

    typedef enum logic [1:0] {
        PAIR_LOCKED = 2'd0,
        PAIR_MIXED  = 2'd1,
        PAIR_FREE   = 2'd2
    } pair_class_e;
endpackage

// File: rtl/lpm_classify.sv
module lpm_classify
    import lpm_pkg::*;
(
    input  logic        lock_a,
    input  logic        lock_b,
    output pair_class_e cls
);
    always_comb begin
        unique case ({lock_a, lock_b})
            2'b11:          cls = PAIR_LOCKED;
            2'b00:          cls = PAIR_FREE;
            2'b01, 2'b10:   cls = PAIR_MIXED;
            default:        cls = PAIR_MIXED;
        endcase
    end
endmodule

// File: rtl/lpm_timeout.sv
module lpm_timeout #(
    parameter int TIMEOUT_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_TICKS);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (tick && count != LIMIT) begin
            count <= count + 1'b1;
        end
    end

    assign expired = run && tick && (count == LIMIT);

    // R4
    tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count != LIMIT) |=> (count == $past(count) + 1'b1));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (count == $past(count)));
endmodule

// File: rtl/lock_pair_monitor.sv
module lock_pair_monitor
    import lpm_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       lock_a,
    input  logic       lock_b,
    output logic [2:0] mode,
    output logic       fault
);
    pair_class_e cls;
    lpm_state_e  state_q;
    lpm_state_e  state_d;
    logic        split_run;
    logic        expired;

    lpm_classify u_cls (
        .lock_a (lock_a),
        .lock_b (lock_b),
        .cls    (cls)
    );

    assign split_run = (state_q == ST_SPLIT);

    lpm_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (split_run),
        .tick    (tick),
        .expired (expired)
    );

    function automatic lpm_state_e settle_or_diverge(input pair_class_e c);
        unique case (c)
            PAIR_LOCKED: return ST_BOTH_LOCKED;
            PAIR_FREE:   return ST_BOTH_FREE;
            default:     return ST_SPLIT;
        endcase
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BOTH_LOCKED, ST_BOTH_FREE: begin
                state_d = settle_or_diverge(cls);
            end
            ST_SPLIT: begin
                if (cls == PAIR_MIXED) begin
                    state_d = expired ? ST_FAULT : ST_SPLIT;
                end else begin
                    state_d = settle_or_diverge(cls);
                end
            end
            ST_FAULT: begin
                if (cls == PAIR_MIXED) begin
                    state_d = ST_FAULT;
                end else begin
                    state_d = settle_or_diverge(cls);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mode  = state_q;
        fault = (state_q == ST_FAULT);
    end

    // R1
    both_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_a && lock_b) |=> (mode == 3'd1));

    // R3
    both_free_chk: assert property (@(posedge clk) disable iff (rst)
        (!lock_a && !lock_b) |=> (mode == 3'd3));

    // R2
    split_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2) |-> $past(lock_a != lock_b));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && lock_a != lock_b) |=> (mode == 3'd4));

    // R4
    fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && $past(mode) != 3'd4) |-> ($past(mode) == 3'd2 && $past(tick)));

    // R9
    fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fault == (mode == 3'd4));
endmodule

// File: tb/sim_lock_pair_monitor.sv
module sim_lock_pair_monitor;
    localparam int TO = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       lock_a = 1'b0;
    logic       lock_b = 1'b0;
    logic [2:0] mode;
    logic       fault;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lock_pair_monitor #(.TIMEOUT_TICKS(TO)) u0 (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .lock_a (lock_a),
        .lock_b (lock_b),
        .mode   (mode),
        .fault  (fault)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at falling edge, one rising edge, sample at next falling edge
    task automatic step(input logic a, input logic b, input logic t);
        lock_a = a;
        lock_b = b;
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic check_mode(input string req, input int exp);
        check(req, int'(mode), exp);
        check({req, " fault R9"}, int'(fault), (exp == 4) ? 1 : 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        check_mode("R8 in reset", 0);
        rst = 1'b0;
        step(1'b1, 1'b0, 1'b0);
        check_mode("R8 first edge after reset", 2);
    endtask

    task automatic t_basic;
        step(1'b1, 1'b1, 1'b0);
        check_mode("R1 both locked", 1);
        step(1'b0, 1'b1, 1'b0);
        check_mode("R2 only B locked", 2);
        step(1'b1, 1'b0, 1'b0);
        check_mode("R2 only A locked", 2);
        step(1'b0, 1'b0, 1'b0);
        check_mode("R3 both free", 3);
        step(1'b0, 1'b0, 1'b1);
        check_mode("R3 both free stays 3", 3);
        step(1'b1, 1'b1, 1'b0);
        check_mode("R1 relock", 1);
    endtask

    task automatic run_to_fault(input logic a, input logic b);
        step(a, b, 1'b1);
        check_mode("R4 entry edge tick not counted", 2);
        for (int i = 0; i < TO; i++) begin
            step(a, b, 1'b1);
            check_mode("R4 before limit", 2);
        end
        step(a, b, 1'b1);
        check_mode("R4 beyond limit", 4);
    endtask

    task automatic t_timeout;
        step(1'b1, 1'b1, 1'b0);
        run_to_fault(1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        check_mode("R5 side swap holds fault", 4);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
        check_mode("R5 fault held", 4);
        step(1'b1, 1'b1, 1'b0);
        check_mode("R6 recover to locked", 1);
        run_to_fault(1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        check_mode("R6 recover to free", 3);
    endtask

    task automatic t_restart;
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < TO; i++) step(1'b1, 1'b0, 1'b1);
        check_mode("R7 near limit", 2);
        step(1'b1, 1'b1, 1'b0);
        check_mode("R7 agree", 1);
        step(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < TO; i++) step(1'b0, 1'b1, 1'b1);
        check_mode("R7 restarted count", 2);
        step(1'b0, 1'b1, 1'b1);
        check_mode("R7 full count expires", 4);
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_notick;
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0);
        check_mode("R10 no strobe no timeout", 2);
        step(1'b1, 1'b0, 1'b1);
        check_mode("R10 single strobe", 2);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_timeout();
        t_restart();
        t_notick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule